// File: doc/BRIEF.md
# Falling-Edge Phase-Frequency Detector

This block sits at the front of a frequency-synthesis loop. It watches two divided clocks: the reference, which comes from the input clock after the pre-divider, and the feedback, which comes from the oscillator after the main divider. It compares the moments at which each of them falls. When the reference falls first, the block drives a correction that asks the oscillator to speed up. When the feedback falls first, it drives a correction that asks the oscillator to slow down. The correction pulses feed a charge pump, which lies outside this block.

Both divided clocks are treated as asynchronous. Each one passes through a short synchroniser that runs on a fast sampling clock. Each falling edge seen there sets a flag of its own. Once both flags are set, they are cleared together, so a correction pulse lasts as many sampling cycles as separated the two edges.

A lock monitor measures that separation at every comparison. It raises a lock indication after a run of consecutive comparisons in which the separation stays small. A power-down input keeps the whole detector idle and clears its outputs.

Top module: `fall_pfd`

## Requirements
- R1: Only falling edges of `ref_div` and `fb_div` start or end a comparison. A rising edge on either input, with the other input steady, leaves `up` and `dn` low.
- R2: When `ref_div` falls N sampling cycles before `fb_div`, `up` is high for exactly N cycles and `dn` stays low.
- R3: When `fb_div` falls N sampling cycles before `ref_div`, `dn` is high for exactly N cycles and `up` stays low.
- R4: When both inputs fall in the same sampling cycle, neither `up` nor `dn` is asserted.
- R5: `up` and `dn` are never high in the same cycle.
- R6: Once both falling edges of a comparison have been seen, both flags clear on the next cycle, and `up` and `dn` stay low until the next falling edge.
- R7: `locked` goes high after 16 consecutive comparisons whose edge separation is 0 or 1 sampling cycle. It stays high while further comparisons stay within that window.
- R8: A single comparison with a separation of 2 or more cycles drops `locked` and restarts the count of good comparisons.
- R9: While `pwr_dn` is high, `up`, `dn` and `locked` are low. Edges seen during power-down are discarded, and the count of good comparisons restarts.
- R10: After `rst_n` is asserted, `up`, `dn` and `locked` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the divided clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | High holds the detector idle and clears its outputs |
| ref_div | input | 1 | Divided reference clock, asynchronous |
| fb_div | input | 1 | Divided feedback clock, asynchronous |
| up | output | 1 | Request for a higher oscillator frequency |
| dn | output | 1 | Request for a lower oscillator frequency |
| locked | output | 1 | High after a run of small-separation comparisons |

## Verification
The bench drives several kinds of edge pair:
- Pairs where the reference leads and pairs where it lags. These tell the two polarities apart, and the width of each pulse is checked against the separation that was applied.
- Pairs that fall in the same cycle. These show that a zero error produces no correction.
- A rising-edge-only stimulus. This shows that the detector reacts to falling edges alone.
- A run of comparisons whose separation grows steadily, as a frequency difference between the two clocks would produce. This stresses the lock monitor, which is also taken across its 16-comparison threshold and knocked out of lock by a single wide separation.
- A power-down issued in the middle of a comparison. This checks that half-finished state is thrown away.
- Seeded random pairs, which mix direction and separation.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned SEP_W_DEF       = 8;
  localparam int unsigned LOCK_RUN_DEF    = 16;
  localparam int unsigned LOCK_WIN_DEF    = 1;
  localparam int unsigned N_CH            = 2;
  localparam int unsigned CH_REF          = 0;
  localparam int unsigned CH_FB           = 1;
endpackage

// File: rtl/pfd_fall_sync.sv
module pfd_fall_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  localparam int unsigned TOP = STAGES;

  logic [TOP:0] chain_q;
  logic [TOP:0] chain_d;

  always_comb begin
    chain_d = {chain_q[TOP-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // previous synchronised level high, current low
  assign fall = chain_q[TOP] & ~chain_q[TOP-1];
endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic ref_fall,
  input  logic fb_fall,
  output logic ref_flag,
  output logic fb_flag,
  output logic up,
  output logic dn
);
  logic ref_q, fb_q;
  logic ref_d, fb_d;
  logic pair_done;
  logic run_en;

  assign run_en    = ~pwr_dn;
  assign pair_done = ref_q & fb_q;

  always_comb begin
    ref_d = ref_q;
    fb_d  = fb_q;
    if (!run_en) begin
      ref_d = 1'b0;
      fb_d  = 1'b0;
    end else begin
      ref_d = (ref_q & ~pair_done) | ref_fall;
      fb_d  = (fb_q  & ~pair_done) | fb_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= ref_d;
      fb_q  <= fb_d;
    end
  end

  assign ref_flag = ref_q;
  assign fb_flag  = fb_q;
  assign up       = ref_q & ~fb_q & run_en;
  assign dn       = fb_q & ~ref_q & run_en;
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int unsigned SEP_W    = 8,
  parameter int unsigned LOCK_RUN = 16,
  parameter int unsigned LOCK_WIN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic ref_flag,
  input  logic fb_flag,
  output logic locked
);
  localparam int unsigned RUN_W   = $clog2(LOCK_RUN + 1);
  localparam logic [SEP_W-1:0] SEP_MAX = {SEP_W{1'b1}};
  localparam logic [SEP_W-1:0] WIN_V   = SEP_W'(LOCK_WIN);
  localparam logic [RUN_W-1:0] RUN_V   = RUN_W'(LOCK_RUN);

  logic [SEP_W-1:0] sep_q, sep_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic one_set, both_set, run_en;

  assign run_en   = ~pwr_dn;
  assign one_set  = ref_flag ^ fb_flag;
  assign both_set = ref_flag & fb_flag;

  always_comb begin
    sep_d = sep_q;
    run_d = run_q;
    if (!run_en) begin
      sep_d = '0;
      run_d = '0;
    end else if (both_set) begin
      sep_d = '0;
      if (sep_q <= WIN_V) begin
        if (run_q != RUN_V) run_d = run_q + 1'b1;
      end else begin
        run_d = '0;
      end
    end else if (one_set) begin
      if (sep_q != SEP_MAX) sep_d = sep_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sep_q <= '0;
      run_q <= '0;
    end else begin
      sep_q <= sep_d;
      run_q <= run_d;
    end
  end

  assign locked = (run_q == RUN_V) & run_en;
endmodule

// File: rtl/fall_pfd.sv
module fall_pfd #(
  parameter int unsigned SYNC_STAGES = pfd_pkg::SYNC_STAGES_DEF,
  parameter int unsigned SEP_W       = pfd_pkg::SEP_W_DEF,
  parameter int unsigned LOCK_RUN    = pfd_pkg::LOCK_RUN_DEF,
  parameter int unsigned LOCK_WIN    = pfd_pkg::LOCK_WIN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic ref_div,
  input  logic fb_div,
  output logic up,
  output logic dn,
  output logic locked
);
  logic [pfd_pkg::N_CH-1:0] clk_in;
  logic [pfd_pkg::N_CH-1:0] fall_p;
  logic ref_flag, fb_flag;

  assign clk_in[pfd_pkg::CH_REF] = ref_div;
  assign clk_in[pfd_pkg::CH_FB]  = fb_div;

  for (genvar ch = 0; ch < pfd_pkg::N_CH; ch++) begin : g_sync
    pfd_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (clk_in[ch]),
      .fall (fall_p[ch])
    );
  end

  pfd_flag_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_dn  (pwr_dn),
    .ref_fall(fall_p[pfd_pkg::CH_REF]),
    .fb_fall (fall_p[pfd_pkg::CH_FB]),
    .ref_flag(ref_flag),
    .fb_flag (fb_flag),
    .up      (up),
    .dn      (dn)
  );

  pfd_lock_mon #(
    .SEP_W   (SEP_W),
    .LOCK_RUN(LOCK_RUN),
    .LOCK_WIN(LOCK_WIN)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_dn  (pwr_dn),
    .ref_flag(ref_flag),
    .fb_flag (fb_flag),
    .locked  (locked)
  );
endmodule

// File: rtl/fall_pfd_chk.sv
module fall_pfd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_dn,
  input logic       up,
  input logic       dn,
  input logic       locked,
  input logic       ref_flag,
  input logic       fb_flag,
  input logic [1:0] fall_p
);
  // R5
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  // R6
  p_pair_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_flag && fb_flag && fall_p == 2'b00 && !pwr_dn) |=> (!ref_flag && !fb_flag));

  // R1
  p_flag_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_flag) |-> $past(fall_p[0]));

  // R1
  p_fb_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_flag) |-> $past(fall_p[1]));

  // R9
  p_pd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!ref_flag && !fb_flag));

  // R7
  p_lock_after_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_flag && fb_flag));
endmodule

bind fall_pfd fall_pfd_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwr_dn  (pwr_dn),
  .up      (up),
  .dn      (dn),
  .locked  (locked),
  .ref_flag(ref_flag),
  .fb_flag (fb_flag),
  .fall_p  (fall_p)
);

// File: tb/tb_fall_pfd.sv
module tb_fall_pfd;
  localparam int CLK_P  = 10;
  localparam int STAGES = 2;
  localparam int RUN    = 16;

  logic clk = 1'b0;
  logic rst_n, pwr_dn, ref_div, fb_div;
  logic up, dn, locked;

  int n_chk = 0;
  int n_bad = 0;
  int good_run = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fall_pfd dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
    .ref_div(ref_div), .fb_div(fb_div),
    .up(up), .dn(dn), .locked(locked)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_up(int d_ref, int d_fb);
    return (d_fb > d_ref) ? d_fb - d_ref : 0;
  endfunction

  function automatic int exp_dn(int d_ref, int d_fb);
    return (d_ref > d_fb) ? d_ref - d_fb : 0;
  endfunction

  function automatic int next_run(int run, int sep);
    if (sep <= 1) return (run < RUN) ? run + 1 : RUN;
    return 0;
  endfunction

  // one comparison: ref falls at cycle d_ref, fb at cycle d_fb
  task automatic cmp(int d_ref, int d_fb, string tag);
    int wu = 0, wd = 0, wb = 0;
    int w  = ((d_ref > d_fb) ? d_ref : d_fb) + STAGES + 8;
    int sep = (d_ref > d_fb) ? d_ref - d_fb : d_fb - d_ref;
    for (int c = 0; c < w; c++) begin
      @(negedge clk);
      if (up) wu++;
      if (dn) wd++;
      if (up && dn) wb++;
      if (c == d_ref) ref_div = 1'b0;
      if (c == d_fb)  fb_div  = 1'b0;
    end
    @(negedge clk);
    chk({tag, " R6 up idle after pair"}, int'(up), 0);
    chk({tag, " R6 dn idle after pair"}, int'(dn), 0);
    ref_div = 1'b1;
    fb_div  = 1'b1;
    repeat (4) @(negedge clk);
    chk({tag, " up width (R2)"}, wu, exp_up(d_ref, d_fb));
    chk({tag, " dn width (R3)"}, wd, exp_dn(d_ref, d_fb));
    chk({tag, " R5 overlap"}, wb, 0);
    good_run = next_run(good_run, sep);
    chk({tag, " lock R7/R8"}, int'(locked), int'(good_run == RUN));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd7719);
    rst_n = 1'b0; pwr_dn = 1'b0; ref_div = 1'b1; fb_div = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 up", int'(up), 0);
    chk("R10 dn", int'(dn), 0);
    chk("R10 locked", int'(locked), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    cmp(2, 7, "R2 lead5");
    cmp(2, 3, "R2 lead1");
    cmp(9, 2, "R3 lag7");
    cmp(3, 2, "R3 lag1");
    cmp(4, 4, "R4 aligned");

    // R1: rising edges alone must not trigger
    begin
      int wu = 0, wd = 0;
      @(negedge clk); ref_div = 1'b0; fb_div = 1'b0;
      repeat (10) @(negedge clk);
      good_run = next_run(good_run, 0);
      ref_div = 1'b1;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (c == 6) fb_div = 1'b1;
        if (up) wu++;
        if (dn) wd++;
      end
      chk("R1 up on rising", wu, 0);
      chk("R1 dn on rising", wd, 0);
    end

    // R7: build the run to lock
    for (int i = 0; i < 18; i++) begin
      if (i % 3 == 1) cmp(3, 4, "R7 run");
      else            cmp(3, 3, "R7 run");
    end
    chk("R7 locked reached", int'(locked), 1);

    // R8: one wide separation drops lock
    cmp(2, 4, "R8 drop");
    chk("R8 locked dropped", int'(locked), 0);

    // frequency difference: steadily growing separation
    for (int k = 0; k < 6; k++) cmp(2, 2 + 3 * k, "R2 drift");

    // R9: power-down in mid comparison after relocking
    for (int i = 0; i < 17; i++) cmp(3, 3, "R7 relock");
    chk("R7 relocked", int'(locked), 1);
    @(negedge clk); ref_div = 1'b0;
    repeat (STAGES + 3) @(negedge clk);
    chk("R2 up before pd", int'(up), 1);
    pwr_dn = 1'b1;
    @(negedge clk);
    chk("R9 up cleared", int'(up), 0);
    chk("R9 locked cleared", int'(locked), 0);
    fb_div = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 dn held off", int'(dn), 0);
    ref_div = 1'b1; fb_div = 1'b1;
    repeat (6) @(negedge clk);
    pwr_dn = 1'b0;
    good_run = 0;
    repeat (4) @(negedge clk);
    chk("R9 up after pd", int'(up), 0);
    chk("R9 dn after pd", int'(dn), 0);
    chk("R9 locked after pd", int'(locked), 0);

    // seeded random pairs
    for (int i = 0; i < 40; i++) begin
      int dir = $urandom_range(0, 2);
      int sep = $urandom_range(1, 10);
      if (dir == 0)      cmp(2, 2 + sep, "R2 rand");
      else if (dir == 1) cmp(2 + sep, 2, "R3 rand");
      else               cmp(3, 3, "R4 rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule